// File: doc/BRIEF.md
# Sorted-Array Binary Search Engine

The block finds an 8-bit unsigned key in a table of 32 eight-bit unsigned words kept in ascending order. It halves the search interval on each step. It reads the middle word of the current interval, compares it with the key, and then either stops on a match or narrows to the half that can still hold the key. A control state machine and a separate datapath exchange a small set of control and status signals. The table sits in an on-chip memory whose address input is registered. That memory has a plain write port so the table can be loaded before a search.

The start request may come from an asynchronous source, so it passes through a two-flop synchroniser. A search begins when the synchronised request is seen high. When the search ends, the block raises done and reports whether the key was found and, if so, its 5-bit location. The result holds until the request has been released and pressed again. A search needs at most six probes. Each probe takes two cycles: one to present the address and one to compare the word that comes back.

Top module: `bsearch_top`

## Requirements
- R1: For a table of distinct ascending words, a search for any stored word ends with found_o=1 and loc_o equal to that word's index.
- R2: Each probe reads index mid=(lo+hi)>>1 of the current interval [lo,hi], starting from [0,31]. If the word there is greater than the key, the next interval is [lo,mid-1]. If it is smaller, the next interval is [mid+1,hi]. mid always lies inside [lo,hi].
- R3: The key and the table words are compared as unsigned values, so key 8'hFF is greater than every other word and is found at index 31 when stored there.
- R4: A key that is not in the table ends with found_o=0. This holds for a key below the smallest word, where mid reaches 0, and for a key above the largest word, where mid reaches 31. The interval never wraps.
- R5: found_o is high only while done_o is high. When done_o=1 and found_o=0, loc_o is 0.
- R6: Once done_o rises, done_o, found_o and loc_o hold for as long as the synchronised start stays high, and after it is released. A new search begins only after a release followed by a new press.
- R7: start_i passes through two flops. If start_i is first sampled high at clock edge e0 and the search takes p probes, then done_o rises after edge e(2+2p). A done_o left over from a previous search falls after edge e2, and done_o stays low in between.
- R8: A search takes at most 6 probes, which is 12 cycles with busy state.
- R9: After reset, done_o, found_o and loc_o are 0.
- R10: A write with wr_en_i high at a clock edge stores wr_data_i at wr_addr_i, and later searches use the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Search request, asynchronous, level |
| key_i | input | 8 | Key to look up, captured when the search begins |
| wr_en_i | input | 1 | Table write enable |
| wr_addr_i | input | 5 | Table write index |
| wr_data_i | input | 8 | Table write word |
| loc_o | output | 5 | Index of the matching word, 0 when not found |
| found_o | output | 1 | Key was located |
| done_o | output | 1 | Search finished, result valid |

## Verification
The hardest cases are the edges of the interval. A key below the smallest word drives mid down to 0, where the next step would compute mid-1. A key of 8'hFF drives mid up to 31, where the next step would compute mid+1. Neither case is reached unless the table is built for it. The stimulus therefore uses two tables. The first leaves both 0 and 255 absent. The second holds 0 at the bottom and 255 at the top. Both ends are searched in each table. The bench also re-presses start while done is still high, so the exact cycle at which the old result drops can be compared against the per-clock model.

// File: rtl/bsearch_pkg.sv
package bsearch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SET,
    ST_CMP,
    ST_FIN
  } bs_state_e;

  typedef struct packed {
    logic init;
    logic ld_lo;
    logic ld_hi;
    logic hit;
  } bs_ctl_t;

  typedef struct packed {
    logic eq;
    logic gt;
    logic at_lo;
    logic at_hi;
  } bs_sts_t;
endpackage

// File: rtl/bsearch_sync.sv
module bsearch_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/bsearch_mem.sv
module bsearch_mem #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  // registered address: data follows the address by one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= rd_addr_i;
  end

  assign rd_data_o = mem_q[addr_q];
endmodule

// File: rtl/bsearch_ctrl.sv
module bsearch_ctrl
  import bsearch_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  bs_sts_t sts_i,
  output bs_ctl_t ctl_o,
  output logic    busy_o,
  output logic    done_o
);
  bs_state_e state_q, state_d;
  logic      armed_q, armed_d;

  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    ctl_o   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ctl_o.init = 1'b1;
          state_d    = ST_SET;
        end
      end
      ST_SET: state_d = ST_CMP;
      ST_CMP: begin
        if (sts_i.eq) begin
          ctl_o.hit = 1'b1;
          state_d   = ST_FIN;
        end else if (sts_i.gt) begin
          if (sts_i.at_lo) state_d = ST_FIN;
          else begin
            ctl_o.ld_hi = 1'b1;
            state_d     = ST_SET;
          end
        end else begin
          if (sts_i.at_hi) state_d = ST_FIN;
          else begin
            ctl_o.ld_lo = 1'b1;
            state_d     = ST_SET;
          end
        end
      end
      ST_FIN: begin
        if (!start_i) armed_d = 1'b1;
        if (armed_q && start_i) begin
          ctl_o.init = 1'b1;
          armed_d    = 1'b0;
          state_d    = ST_SET;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
    end
  end

  assign busy_o = (state_q == ST_SET) || (state_q == ST_CMP);
  assign done_o = (state_q == ST_FIN);
endmodule

// File: rtl/bsearch_dp.sv
module bsearch_dp
  import bsearch_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bs_ctl_t       ctl_i,
  input  logic [DW-1:0] key_i,
  input  logic [DW-1:0] rd_data_i,
  output bs_sts_t       sts_o,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] lo_o,
  output logic [AW-1:0] hi_o,
  output logic [AW-1:0] loc_o,
  output logic          found_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] lo_q, hi_q, loc_q, mid;
  logic [AW:0]   sum;
  logic [DW-1:0] key_q;
  logic          found_q;

  assign sum = {1'b0, lo_q} + {1'b0, hi_q};
  assign mid = sum[AW:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      hi_q    <= '1;
      key_q   <= '0;
      loc_q   <= '0;
      found_q <= 1'b0;
    end else begin
      if (ctl_i.init) begin
        lo_q    <= '0;
        hi_q    <= '1;
        key_q   <= key_i;
        loc_q   <= '0;
        found_q <= 1'b0;
      end
      // bounds move only when the interval still has room on that side
      if (ctl_i.ld_lo) lo_q <= mid + ONE;
      if (ctl_i.ld_hi) hi_q <= mid - ONE;
      if (ctl_i.hit) begin
        loc_q   <= mid;
        found_q <= 1'b1;
      end
    end
  end

  assign sts_o.eq    = (rd_data_i == key_q);
  assign sts_o.gt    = (rd_data_i > key_q);
  assign sts_o.at_lo = (mid == lo_q);
  assign sts_o.at_hi = (mid == hi_q);

  assign addr_o  = mid;
  assign lo_o    = lo_q;
  assign hi_o    = hi_q;
  assign loc_o   = loc_q;
  assign found_o = found_q;
endmodule

// File: rtl/bsearch_top.sv
module bsearch_top
  import bsearch_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] key_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [AW-1:0] loc_o,
  output logic          found_o,
  output logic          done_o
);
  logic          start_s, busy;
  bs_ctl_t       ctl;
  bs_sts_t       sts;
  logic [AW-1:0] mid, lo, hi;
  logic [DW-1:0] rd_data;

  bsearch_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (start_i),
    .q_o   (start_s)
  );

  bsearch_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_s),
    .sts_i  (sts),
    .ctl_o  (ctl),
    .busy_o (busy),
    .done_o (done_o)
  );

  bsearch_dp #(.DW(DW), .AW(AW)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_i    (ctl),
    .key_i    (key_i),
    .rd_data_i(rd_data),
    .sts_o    (sts),
    .addr_o   (mid),
    .lo_o     (lo),
    .hi_o     (hi),
    .loc_o    (loc_o),
    .found_o  (found_o)
  );

  bsearch_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_addr_i(mid),
    .rd_data_o(rd_data)
  );
endmodule

// File: rtl/bsearch_chk.sv
module bsearch_chk #(
  parameter int AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          start_s,
  input logic          busy,
  input logic [AW-1:0] lo,
  input logic [AW-1:0] hi,
  input logic [AW-1:0] mid,
  input logic [AW-1:0] loc_o,
  input logic          found_o,
  input logic          done_o
);
  localparam int MAX_CYC = 2 * (AW + 1);

  logic [1:0] since_rst;
  int         busy_cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst <= '0;
      busy_cyc  <= 0;
    end else begin
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      busy_cyc <= busy ? busy_cyc + 1 : 0;
    end
  end

  AST_MID_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (lo <= mid) && (mid <= hi)); // R2

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> lo <= hi); // R4

  AST_FOUND_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> done_o); // R5

  AST_MISS_LOC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !found_o) |-> loc_o == '0); // R5

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> ($stable(found_o) && $stable(loc_o))); // R6

  AST_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2) |-> start_s == $past(start_i, 2)); // R7

  AST_PROBE_BUDGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cyc <= MAX_CYC); // R8
endmodule

bind bsearch_top bsearch_chk #(.AW(AW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .start_s(start_s),
  .busy   (busy),
  .lo     (lo),
  .hi     (hi),
  .mid    (mid),
  .loc_o  (loc_o),
  .found_o(found_o),
  .done_o (done_o)
);

// File: tb/bsearch_top_bench.sv
module bsearch_top_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] key_i = '0;
  logic       wr_en_i = 1'b0;
  logic [4:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [4:0] loc_o;
  logic       found_o, done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit ended = 0;
  logic [7:0] tbl [32];

  bsearch_top u_bsearch_top (.*);

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000 && !ended) begin
      ended = 1;
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic load(input int kind);
    for (int i = 0; i < 32; i++) begin
      if (kind == 0) tbl[i] = 8'(3 + 8 * i);
      else           tbl[i] = (i == 31) ? 8'hFF : 8'(8 * i);
      @(negedge clk_i);
      wr_en_i = 1'b1; wr_addr_i = 5'(i); wr_data_i = tbl[i];
    end
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // reference: probe count from the halving rule, result from a linear scan
  task automatic run(input logic [7:0] key, input string req);
    int lo = 0, hi = 31, mid, p = 0, eloc = 0, efnd = 0, lat;
    bit prev;
    forever begin
      mid = (lo + hi) / 2;
      p++;
      if (tbl[mid] == key) break;
      if (tbl[mid] > key) begin
        if (mid == lo) break;
        hi = mid - 1;
      end else begin
        if (mid == hi) break;
        lo = mid + 1;
      end
    end
    for (int i = 0; i < 32; i++) if (tbl[i] == key) begin efnd = 1; eloc = i; end
    lat = 2 + 2 * p;
    chk("R8", "probe budget", int'(p <= 6), 1);
    prev = done_o;
    key_i = key;
    start_i = 1'b1;
    for (int k = 0; k <= lat + 3; k++) begin
      @(negedge clk_i);
      if (k < 2) begin
        chk("R7", "done before sync", done_o, prev);
      end else if (k < lat) begin
        chk("R7", "done while busy", done_o, 0);
        chk("R5", "found while busy", found_o, 0);
      end else begin
        chk("R7", "done at latency", done_o, 1);
        chk(req, "found", found_o, efnd);
        chk(req, "loc", loc_o, eloc);
      end
    end
    start_i = 1'b0;
    key_i = ~key;
    repeat (4) begin
      @(negedge clk_i);
      chk("R6", "done after release", done_o, 1);
      chk("R6", "found after release", found_o, efnd);
      chk("R6", "loc after release", loc_o, eloc);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9", "done", done_o, 0);
    chk("R9", "found", found_o, 0);
    chk("R9", "loc", loc_o, 0);

    load(0);
    for (int i = 0; i < 32; i++) run(tbl[i], "R1");
    run(8'd0, "R4");
    run(8'd255, "R4");
    run(8'd1, "R4");
    run(8'd4, "R4");
    run(8'd250, "R4");
    run(8'd128, "R2");
    run(8'd2, "R4");

    load(1);
    run(8'hFF, "R3");
    run(8'd0, "R10");
    run(8'd248, "R3");
    run(8'd254, "R3");
    run(8'd8, "R10");
    run(8'd4, "R2");

    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule